// File: doc/BRIEF.md
# Unlock-Protected Clock Divide Control

This block turns a fast master clock into a slower system tick by raising a single-cycle enable output once every N master cycles. N is a power of two, from 1 to 256, chosen by a 4-bit select field held in one 8-bit software register. Downstream logic qualifies its flops with the enable rather than running on a gated clock.

The select field is guarded against stray writes. Software must first write a lone unlock value, which opens a short window of four cycles. Only inside that window does a write reach the select field, and such a write also closes the window at once. Outside the window, every write other than the unlock value is dropped. At reset the select field takes one of two defaults, picked by a strap input. The default gives divide-by-1 when the strap is low and divide-by-8 when the strap is high.

A new factor never cuts a period short. The divider finishes the period it is in and switches only at the next output pulse. Reserved codes are stored and read back, but they do not change the division in use.

Top module: `clk_prescale_ctl`

## Requirements
- R1: The read value carries the window flag in bit 7 and the select field in bits 3..0. Bits 6..4 always read as zero.
- R2: While the window is closed, only a write of exactly 0x80 opens it. Any other value, including 0x80 with some other bit also set, leaves it closed.
- R3: After the opening write, bit 7 reads 1 during the four cycles that follow and 0 after them. A select write is accepted in any of those four cycles and not in the fifth.
- R4: Writing 0x80 again while the window is open neither clears bit 7 nor extends the four-cycle window.
- R5: Inside the window, any write other than 0x80 stores its bits 3..0 into the select field and clears bit 7 in the next cycle.
- R6: While the window is closed, writes other than 0x80 change neither the select field nor bit 7.
- R7: Select codes 0 to 8 make the enable pulse every 2^code cycles. With code 0 the enable is high on every cycle.
- R8: A reserved code from 9 to 15, written inside the window, reads back as written. The pulse spacing stays at the last valid factor.
- R9: After a valid code is accepted, the first pulse interval is either the old or the new period. Every later interval equals the new period, so no shortened or merged period ever appears.
- R10: At reset the select field loads 0000 when the strap is low and 0011 when it is high. The pulse spacing matches the loaded code.
- R11: Once unlocked, any select value is accepted whatever the strap level. For example, code 0 gives divide-by-1 after a strap-high reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_div8 | input | 1 | Reset default select: high loads divide-by-8, low loads divide-by-1 |
| wr_en | input | 1 | Register write strobe, sampled on the rising clock edge |
| wr_data | input | 8 | Register write value |
| rd_data | output | 8 | Register read value: window flag, zeros, select field |
| clk_en_o | output | 1 | Single-cycle system tick enable |

## Verification
A write sampled at edge k shows in rd_data from edge k itself, so the bench reads the register on the falling edge right after the write. The window flag is then sampled on the next four falling edges, where it must be 1, and on the fifth, where it must be 0. Pulse spacing is measured in falling edges between enable highs. The first interval after a change may still run at the old period, because the switch waits for the wrap edge. The bench therefore accepts either period for that interval and demands the exact new period for the two intervals that follow.

// File: rtl/clk_prescale_ctl.sv
`timescale 1ns/1ps
module clk_prescale_ctl #(
  parameter int              WIN_CYC    = 4,
  parameter int              SEL_W      = 4,
  parameter int              MAX_CODE   = 8,
  parameter logic [7:0]      UNLOCK_VAL = 8'h80,
  parameter logic [SEL_W-1:0] STRAP_CODE = SEL_W'(3)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strap_div8,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       clk_en_o
);
  localparam int CW  = MAX_CODE;
  localparam int WCW = $clog2(WIN_CYC + 1);

  logic             win_q;
  logic [WCW-1:0]   win_cnt;
  logic [SEL_W-1:0] sel_q, tgt_q, act_q;
  logic [CW-1:0]    div_cnt;
  logic [CW:0]      span;

  wire unlock_hit = wr_en && (wr_data == UNLOCK_VAL);
  wire sel_wr     = wr_en && win_q && !unlock_hit;
  wire code_ok    = int'(wr_data[SEL_W-1:0]) <= MAX_CODE;
  wire [SEL_W-1:0] rst_code = strap_div8 ? STRAP_CODE : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q   <= 1'b0;
      win_cnt <= '0;
    end else if (!win_q) begin
      if (unlock_hit) begin
        win_q   <= 1'b1;
        win_cnt <= WCW'(WIN_CYC);
      end
    end else if (sel_wr || win_cnt == WCW'(1)) begin
      win_q   <= 1'b0;
      win_cnt <= '0;
    end else begin
      win_cnt <= win_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= rst_code;
      tgt_q <= rst_code;
    end else if (sel_wr) begin
      sel_q <= wr_data[SEL_W-1:0];
      if (code_ok) tgt_q <= wr_data[SEL_W-1:0];
    end
  end

  assign span = ({{CW{1'b0}}, 1'b1} << act_q) - 1'b1;
  wire wrap = div_cnt == span[CW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
      act_q   <= rst_code;
    end else if (wrap) begin
      div_cnt <= '0;
      act_q   <= tgt_q;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end

  assign clk_en_o = div_cnt == '0;
  assign rd_data  = {win_q, {(7-SEL_W){1'b0}}, sel_q};

  // R6
  locked_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !win_q && wr_data != UNLOCK_VAL) |=> (!win_q && $stable(sel_q)));

  // R4
  rewrite_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_q && win_cnt > WCW'(1) && unlock_hit) |=> (win_q && win_cnt == $past(win_cnt) - 1'b1));

  // R5
  sel_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr |=> !win_q);

  // R2
  open_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(win_q) |-> $past(unlock_hit));

  // R9
  act_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q != $past(act_q)) |-> clk_en_o);

  // R7
  div1_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q == '0) |-> clk_en_o);

  // R8
  tgt_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(tgt_q) <= MAX_CODE);
endmodule

// File: tb/clk_prescale_ctl_bench.sv
`timescale 1ns/1ps
module clk_prescale_ctl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strap = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic clk_en_o;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  clk_prescale_ctl u_clk_prescale_ctl (
    .clk(clk), .rst_n(rst_n), .strap_div8(strap), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .clk_en_o(clk_en_o)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic do_reset(logic s);
    rst_n = 1'b0; strap = s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic interval(output int n);
    while (!clk_en_o) @(negedge clk);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!clk_en_o);
  endtask

  task automatic set_code(logic [7:0] c);
    wr(8'h80);
    wr(c);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int i1, i2, i3, old_p, new_p, cur;
    @(negedge clk);
    do_reset(1'b0);
    chk("R10 strap low default", rd_data, 8'h00);
    chk("R7 div1 enable high", clk_en_o, 1);
    interval(i1);
    chk("R10 strap low spacing", i1, 1);

    old_p = 1;
    for (int c = 0; c <= 8; c++) begin
      new_p = 1 << c;
      set_code(8'(c));
      chk("R5 select stored, window closed", rd_data, c);
      interval(i1); interval(i2); interval(i3);
      chk("R9 first interval old or new", int'(i1 == old_p || i1 == new_p), 1);
      chk("R7 spacing", i2, new_p);
      chk("R7 spacing repeat", i3, new_p);
      old_p = new_p;
    end

    set_code(8'h02);
    interval(i1); interval(i1);
    set_code(8'h0B);
    chk("R8 reserved readback", rd_data, 8'h0B);
    interval(i1); interval(i2); interval(i3);
    chk("R8 keeps last valid", i2, 4);
    chk("R8 keeps last valid repeat", i3, 4);
    set_code(8'h0F);
    chk("R8 reserved 15 readback", rd_data, 8'h0F);
    interval(i1); interval(i2);
    chk("R8 spacing after 15", i2, 4);

    set_code(8'h01);
    wr(8'h80);
    chk("R3 flag cycle 1", rd_data[7], 1);
    for (int k = 2; k <= 4; k++) begin
      @(negedge clk);
      chk("R3 flag open", rd_data[7], 1);
    end
    @(negedge clk);
    chk("R3 flag clears after four", rd_data[7], 0);

    wr(8'h80);
    repeat (3) @(negedge clk);
    wr(8'h06);
    chk("R3 write in fourth cycle accepted", rd_data, 8'h06);

    wr(8'h80);
    repeat (4) @(negedge clk);
    wr(8'h03);
    chk("R6 write in fifth cycle ignored", rd_data, 8'h06);

    wr(8'h80);
    wr(8'h80);
    chk("R4 rewrite does not clear", rd_data[7], 1);
    @(negedge clk);
    chk("R4 open cycle 3", rd_data[7], 1);
    @(negedge clk);
    chk("R4 open cycle 4", rd_data[7], 1);
    @(negedge clk);
    chk("R4 rewrite does not extend", rd_data[7], 0);

    cur = rd_data;
    wr(8'h81);
    chk("R2 0x81 does not open", rd_data, cur);
    wr(8'h05);
    chk("R6 locked select write ignored", rd_data, cur);
    wr(8'h00);
    chk("R6 locked zero write ignored", rd_data, cur);

    wr(8'h80);
    wr(8'hF5);
    chk("R1 bits 6..4 zero, R5 close", rd_data, 8'h05);

    do_reset(1'b1);
    chk("R10 strap high default", rd_data, 8'h03);
    interval(i1); interval(i2);
    chk("R10 strap high spacing", i2, 8);
    set_code(8'h00);
    chk("R11 code 0 under strap high", rd_data, 8'h00);
    interval(i1); interval(i2); interval(i3);
    chk("R11 div1 spacing", i2, 1);
    chk("R11 div1 spacing repeat", i3, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule